// File: doc/BRIEF.md
# Clock Multiplier/Divider Search Engine

This unit picks the integer multiplier M and the pre-divider N for a synthesized clock so that M times the quotient of a fixed reference frequency by N comes as close as possible to a requested frequency. A one-cycle start pulse captures a target in Hz. The engine then visits candidate pairs one per clock, M in the outer loop and N in the inner loop. It keeps the pair with the smallest absolute error seen so far. When the walk is over it raises a done flag and presents M, N minus one and the remaining error.

The quotient is formed first by integer division and only then multiplied by M. The per-N quotients are fixed by the reference, so they are computed at elaboration time into a small table. In typical use the caller passes twice the desired pixel clock: a pixel clock given in kHz is multiplied by 2000 to give the target in Hz. Programming the clock generator with the result is left to the caller.

Top module: `mn_search`

## Requirements
- R1: After reset, busy_o and done_o are 0, mult_o is 1, div_m1_o is 0 and err_o is 0.
- R2: Each candidate frequency equals M × floor(REF_HZ / N), with the division truncated before the multiply. M covers 1..M_MAX and N covers 1..N_MAX. The reported pair minimises |target − candidate| over all visited pairs.
- R3: Pairs are visited with M ascending in the outer loop and N ascending in the inner loop. A candidate replaces the best pair only when its error is strictly smaller, so on a tie the earlier pair is kept.
- R4: The running best error starts equal to the captured target. If no candidate has an error below the target, the result is mult_o = 1, div_m1_o = 0 and err_o = target.
- R5: One pair is evaluated per clock. Once the best error is zero, the remaining N values of the current M are skipped and the walk resumes at the next M with N = 1. M still runs to M_MAX. done_o rises P+1 rising edges after and including the edge that captures start, where P is the number of pairs evaluated.
- R6: div_m1_o is the chosen N minus 1. mult_o is the chosen M unchanged. err_o is the absolute error of the chosen pair.
- R7: start_i is ignored while busy_o is 1. The captured target and the result are unaffected.
- R8: done_o and all result outputs stay constant until the next start. A start while done_o is 1 begins a new search and clears done_o.
- R9: The target is TGT_W (default 40) bits wide, and products are formed wide enough that M_MAX × REF_HZ cannot overflow. A target above every candidate yields M = M_MAX, N = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse; captures target_i when idle or done |
| target_i | input | TGT_W | Requested frequency in Hz |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | Result valid; held until the next start |
| mult_o | output | $clog2(M_MAX+1) | Chosen multiplier M |
| div_m1_o | output | $clog2(N_MAX+1) | Chosen divider N minus one |
| err_o | output | TGT_W | Absolute error of the chosen pair, in Hz |

## Verification
The bench builds the engine with M_MAX = 63 and N_MAX = 15 while keeping the 24 MHz reference and the 40-bit target. This makes a complete walk at most 945 pairs long, so dozens of full searches fit in one run and every result and latency can be compared against a bench-side loop. With these values the bench can reach the exact-hit shortcut at several positions, ties between equal candidates such as 1×24 MHz and 2×12 MHz, a zero target, a target smaller than any candidate, and a target above the largest product. The full-size walk of about 260,000 cycles is left to the default elaboration.

// File: rtl/mn_search_pkg.sv
package mn_search_pkg;
  typedef enum logic [1:0] {
    WALK_IDLE = 2'd0,
    WALK_RUN  = 2'd1,
    WALK_DONE = 2'd2
  } walk_state_e;

  function automatic int unsigned wmax(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/mn_quot_table.sv
module mn_quot_table #(
  parameter int unsigned REF_HZ = 24_000_000,
  parameter int unsigned N_MAX  = 127,
  localparam int unsigned N_W   = $clog2(N_MAX + 1),
  localparam int unsigned Q_W   = $clog2(REF_HZ + 1)
) (
  input  logic [N_W-1:0] n_i,
  output logic [Q_W-1:0] quot_o
);
  localparam int unsigned DEPTH = 2 ** N_W;

  logic [Q_W-1:0] tab [DEPTH];

  // floor(REF_HZ / n) fixed at elaboration; unused slots hold zero
  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    localparam int unsigned DIV = (g == 0) ? 1 : g;
    if (g == 0 || g > N_MAX) begin : g_zero
      assign tab[g] = '0;
    end else begin : g_val
      assign tab[g] = Q_W'(REF_HZ / DIV);
    end
  end

  assign quot_o = tab[n_i];
endmodule

// File: rtl/mn_err_calc.sv
module mn_err_calc #(
  parameter int unsigned M_W   = 11,
  parameter int unsigned Q_W   = 25,
  parameter int unsigned TGT_W = 40,
  localparam int unsigned E_W  = mn_search_pkg::wmax(TGT_W, M_W + Q_W) + 1
) (
  input  logic [M_W-1:0]   m_i,
  input  logic [Q_W-1:0]   quot_i,
  input  logic [TGT_W-1:0] target_i,
  output logic [E_W-1:0]   err_o
);
  logic [E_W-1:0] cand;
  logic [E_W-1:0] tgt;

  always_comb begin
    cand  = E_W'(m_i) * E_W'(quot_i);
    tgt   = E_W'(target_i);
    err_o = (tgt >= cand) ? (tgt - cand) : (cand - tgt);
  end
endmodule

// File: rtl/mn_pair_walker.sv
module mn_pair_walker
  import mn_search_pkg::*;
#(
  parameter int unsigned M_MAX = 2047,
  parameter int unsigned N_MAX = 127,
  localparam int unsigned M_W  = $clog2(M_MAX + 1),
  localparam int unsigned N_W  = $clog2(N_MAX + 1)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic           zero_i,
  output logic [M_W-1:0] m_o,
  output logic [N_W-1:0] n_o,
  output logic           load_o,
  output logic           busy_o,
  output logic           done_o
);
  walk_state_e state_q;
  logic        row_end;

  assign busy_o  = (state_q == WALK_RUN);
  assign done_o  = (state_q == WALK_DONE);
  assign load_o  = start_i && !busy_o;
  assign row_end = (n_o == N_W'(N_MAX)) || zero_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= WALK_IDLE;
      m_o     <= M_W'(1);
      n_o     <= N_W'(1);
    end else if (load_o) begin
      state_q <= WALK_RUN;
      m_o     <= M_W'(1);
      n_o     <= N_W'(1);
    end else if (busy_o) begin
      if (row_end) begin
        n_o <= N_W'(1);
        if (m_o == M_W'(M_MAX)) state_q <= WALK_DONE;
        else                    m_o     <= m_o + M_W'(1);
      end else begin
        n_o <= n_o + N_W'(1);
      end
    end
  end

  assert_pair_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (m_o >= M_W'(1) && m_o <= M_W'(M_MAX) && n_o >= N_W'(1) && n_o <= N_W'(N_MAX)));

  assert_inner_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !zero_i && n_o != N_W'(N_MAX)) |=> (n_o == $past(n_o) + N_W'(1) && m_o == $past(m_o)));

  assert_exact_skip_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && zero_i && m_o != M_W'(M_MAX)) |=> (n_o == N_W'(1) && m_o == $past(m_o) + M_W'(1)));
endmodule

// File: rtl/mn_search.sv
module mn_search #(
  parameter int unsigned REF_HZ = 24_000_000,
  parameter int unsigned M_MAX  = 2047,
  parameter int unsigned N_MAX  = 127,
  parameter int unsigned TGT_W  = 40,
  localparam int unsigned M_W   = $clog2(M_MAX + 1),
  localparam int unsigned N_W   = $clog2(N_MAX + 1),
  localparam int unsigned Q_W   = $clog2(REF_HZ + 1),
  localparam int unsigned E_W   = mn_search_pkg::wmax(TGT_W, M_W + Q_W) + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [TGT_W-1:0] target_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [M_W-1:0]   mult_o,
  output logic [N_W-1:0]   div_m1_o,
  output logic [TGT_W-1:0] err_o
);
  logic [M_W-1:0]   m_cur;
  logic [N_W-1:0]   n_cur;
  logic [Q_W-1:0]   quot;
  logic [E_W-1:0]   cand_err;
  logic [TGT_W-1:0] tgt_q;
  logic [TGT_W-1:0] best_err_q;
  logic [M_W-1:0]   best_m_q;
  logic [N_W-1:0]   best_n_q;
  logic             load;
  logic             better;
  logic             zero_now;

  mn_quot_table #(.REF_HZ(REF_HZ), .N_MAX(N_MAX)) u_quot (
    .n_i    (n_cur),
    .quot_o (quot)
  );

  mn_err_calc #(.M_W(M_W), .Q_W(Q_W), .TGT_W(TGT_W)) u_err (
    .m_i      (m_cur),
    .quot_i   (quot),
    .target_i (tgt_q),
    .err_o    (cand_err)
  );

  // strict compare keeps the earliest pair on a tie
  assign better   = busy_o && (cand_err < E_W'(best_err_q));
  assign zero_now = better ? (cand_err == '0) : (best_err_q == '0);

  mn_pair_walker #(.M_MAX(M_MAX), .N_MAX(N_MAX)) u_walk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .zero_i  (zero_now),
    .m_o     (m_cur),
    .n_o     (n_cur),
    .load_o  (load),
    .busy_o  (busy_o),
    .done_o  (done_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tgt_q      <= '0;
      best_err_q <= '0;
      best_m_q   <= M_W'(1);
      best_n_q   <= N_W'(1);
    end else if (load) begin
      tgt_q      <= target_i;
      best_err_q <= target_i;
      best_m_q   <= M_W'(1);
      best_n_q   <= N_W'(1);
    end else if (better) begin
      best_err_q <= TGT_W'(cand_err);
      best_m_q   <= m_cur;
      best_n_q   <= n_cur;
    end
  end

  assign mult_o   = best_m_q;
  assign div_m1_o = best_n_q - N_W'(1);
  assign err_o    = best_err_q;

  assert_err_monotone_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> (err_o <= $past(err_o)));

  assert_busy_ignores_start_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> $stable(tgt_q));

  assert_result_held_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> (done_o && $stable(mult_o) && $stable(div_m1_o) && $stable(err_o)));

  assert_done_after_run_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(busy_o));

  assert_err_within_target_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (err_o <= tgt_q));
endmodule

// File: tb/mn_search_tb_top.sv
module mn_search_tb_top;
  localparam int unsigned REF_HZ = 24_000_000;
  localparam int unsigned M_MAX  = 63;
  localparam int unsigned N_MAX  = 15;
  localparam int unsigned TGT_W  = 40;
  localparam int unsigned M_W    = $clog2(M_MAX + 1);
  localparam int unsigned N_W    = $clog2(N_MAX + 1);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [TGT_W-1:0] target = '0;
  logic             busy, done;
  logic [M_W-1:0]   mult;
  logic [N_W-1:0]   div_m1;
  logic [TGT_W-1:0] err;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  mn_search #(.REF_HZ(REF_HZ), .M_MAX(M_MAX), .N_MAX(N_MAX), .TGT_W(TGT_W)) dut_i (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .start_i  (start),
    .target_i (target),
    .busy_o   (busy),
    .done_o   (done),
    .mult_o   (mult),
    .div_m1_o (div_m1),
    .err_o    (err)
  );

  task automatic check(input string req, input longint unsigned act, input longint unsigned exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // behavioural model of the search written from the requirements
  task automatic model(input longint unsigned t, output longint unsigned bm,
                       output longint unsigned bn, output longint unsigned be,
                       output int pairs);
    longint unsigned c, d;
    bm = 1; bn = 1; be = t; pairs = 0;
    for (int m = 1; m <= M_MAX; m++) begin
      for (int n = 1; n <= N_MAX; n++) begin
        pairs++;
        c = longint'(m) * (longint'(REF_HZ) / longint'(n));
        d = (t >= c) ? t - c : c - t;
        if (d < be) begin be = d; bm = m; bn = n; end
        if (be == 0) break;
      end
    end
  endtask

  // launches a search, optionally pokes start mid-run, returns edges until done
  task automatic run(input longint unsigned t, input int poke_at,
                     input longint unsigned poke_t, output int edges);
    @(negedge clk);
    target = TGT_W'(t);
    start  = 1'b1;
    edges  = 0;
    forever begin
      @(posedge clk);
      edges++;
      @(negedge clk);
      if (poke_at > 0 && edges == poke_at) begin
        start  = 1'b1;
        target = TGT_W'(poke_t);
      end else begin
        start = 1'b0;
      end
      if (done || edges > 5000) break;
    end
    start = 1'b0;
  endtask

  task automatic search_and_check(input string req, input longint unsigned t);
    longint unsigned bm, bn, be;
    int pairs, edges;
    model(t, bm, bn, be, pairs);
    run(t, 0, 0, edges);
    check({req, " done"}, done, 1);
    check({req, " R6 mult"}, mult, bm);
    check({req, " R6 div_m1"}, div_m1, bn - 1);
    check({req, " R2 err"}, err, be);
    check({req, " R5 latency"}, edges, pairs + 1);
  endtask

  task automatic test_reset();
    check("R1 busy", busy, 0);
    check("R1 done", done, 0);
    check("R1 mult", mult, 1);
    check("R1 div_m1", div_m1, 0);
    check("R1 err", err, 0);
  endtask

  task automatic test_exact();
    longint unsigned m, n;
    search_and_check("R5 exact 56MHz", 64'd56_000_000);
    for (int i = 0; i < 6; i++) begin
      m = $urandom_range(M_MAX, 1);
      n = $urandom_range(N_MAX, 1);
      search_and_check("R5 exact rnd", m * (REF_HZ / n));
    end
  endtask

  task automatic test_random();
    longint unsigned t;
    for (int i = 0; i < 12; i++) begin
      t = longint'($urandom_range(32'hFFFF_FFFF, 0)) % 64'd1_600_000_000;
      search_and_check("R2 random", t);
    end
    search_and_check("R2 twice 25.175MHz pclk", 64'd25_175 * 2000);
  endtask

  task automatic test_tie();
    // 1x24M and 2x12M give the same candidate; the earlier pair must win
    search_and_check("R3 tie", 64'd24_000_005);
    check("R3 tie first pair mult", mult, 1);
    check("R3 tie first pair div", div_m1, 0);
  endtask

  task automatic test_small();
    search_and_check("R4 zero target", 0);
    search_and_check("R4 tiny target", 5);
    check("R4 tiny err equals target", err, 5);
    check("R4 tiny mult", mult, 1);
  endtask

  task automatic test_huge();
    longint unsigned t;
    t = (64'd1 << TGT_W) - 1;
    search_and_check("R9 huge", t);
    check("R9 huge mult", mult, M_MAX);
    check("R9 huge div", div_m1, 0);
    check("R9 huge err", err, t - longint'(M_MAX) * REF_HZ);
  endtask

  task automatic test_busy_start();
    longint unsigned bm, bn, be;
    int pairs, edges;
    model(64'd333_333_333, bm, bn, be, pairs);
    run(64'd333_333_333, 20, 64'd48_000_000, edges);
    check("R7 mult kept", mult, bm);
    check("R7 err kept", err, be);
    check("R7 latency kept", edges, pairs + 1);
  endtask

  task automatic test_hold();
    longint unsigned m0, d0, e0;
    m0 = mult; d0 = div_m1; e0 = err;
    repeat (25) @(negedge clk);
    check("R8 done held", done, 1);
    check("R8 mult held", mult, m0);
    check("R8 div held", div_m1, d0);
    check("R8 err held", err, e0);
    @(negedge clk);
    start  = 1'b1;
    target = TGT_W'(64'd100_000_000);
    @(negedge clk);
    start = 1'b0;
    check("R8 restart clears done", done, 0);
    check("R8 restart busy", busy, 1);
    while (!done) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    test_reset();
    test_exact();
    test_random();
    test_tie();
    test_small();
    test_huge();
    test_busy_start();
    test_hold();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200_000 * 4 - 40);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule